// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Collector

This block gathers three urgent fault sources of a command-list coprocessor into one sticky status word, and raises a level NMI request toward the host core while any of them is recorded. The three sources are:

- a host access into the coprocessor's address window while the engine is running, unless the access targets one of the control registers that stay open during execution;
- an attempt by the engine to execute a breakpoint or reserved opcode;
- a falling edge on an asynchronous, active-low external NMI pin.

The host's interrupt handler reads the status word to learn the cause. That read wipes every flag. When handlers nest, the inner handler may consume all the flags, so the outer handler can find the word empty. This is intended. All pins are plain control and status signals: single-cycle strobes in and a level value out, with no handshake.

Top module: `nmi_collector`

## Requirements
- R1: After reset `stat_q` is 0 and `nmi_req` is 0.
- R2: A `host_acc` strobe while `eng_run` is 1, whose `host_addr` is not an exempt offset, sets bit 2 (access fault) of `stat_q` from the next clock edge on.
- R3: Accesses during run to the exempt offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 leave bit 2 clear. An offset near one of them, such as 0x02, is not exempt.
- R4: A `host_acc` strobe while `eng_run` is 0 never sets bit 2.
- R5: A `bad_op` strobe sets bit 1 (undefined opcode) from the next clock edge on.
- R6: A falling edge on `nmi_pin_n` sets bit 0 (external) once per edge. With the pin low before rising edge k, the flag is visible after edge k+2. Holding the pin low, or a rising edge, sets nothing more.
- R7: `nmi_req` is 1 exactly while at least one flag of `stat_q` is 1, and it stays high until a clearing read.
- R8: During a `stat_rd` cycle `stat_q` shows the flags held before the read. After that edge, every flag without a new event is 0, and an empty read returns 0.
- R9: A source event in the same cycle as `stat_rd` leaves its own flag set after the edge.
- R10: Bits 15 to 3 of `stat_q` always read 0.
- R11: A set flag stays set until a read clears it or reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_run | input | 1 | Engine is executing its command list |
| host_acc | input | 1 | One-cycle strobe: host accesses the coprocessor window |
| host_addr | input | ADDR_W | Byte offset of that access within the window |
| bad_op | input | 1 | One-cycle strobe: breakpoint or reserved opcode attempted |
| nmi_pin_n | input | 1 | Asynchronous external NMI pin, active on its falling edge |
| stat_rd | input | 1 | One-cycle strobe: host reads the status word (clears it) |
| stat_q | output | STAT_W | Status word: bit 0 external, bit 1 undefined opcode, bit 2 access fault |
| nmi_req | output | 1 | Level NMI request to the host core |

## Verification
The access-fault and opcode flags are due one rising edge after their strobe. The external flag is due two rising edges after the first edge that samples the low pin, and a read takes effect at the edge that ends its cycle. The bench drives each cycle's inputs at the falling clock edge. A moment later it compares `stat_q` and `nmi_req` with the value the previous cycles must have produced, so that a read's pre-clear value and each flag's due cycle are checked at the exact cycle. For the pin, the bench also checks the cycle just before the flag is due, to show that it does not arrive early.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int STAT_W  = 16;
  localparam int N_SRC   = 3;
  localparam int EXT_BIT = 0;
  localparam int UND_BIT = 1;
  localparam int ERR_BIT = 2;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_r;
  logic                   last_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_r <= '1;
      last_r <= 1'b1;
    end else begin
      sync_r <= {sync_r[SYNC_STAGES-2:0], pin_n};
      last_r <= sync_r[SYNC_STAGES-1];
    end
  end

  assign fall = last_r & ~sync_r[SYNC_STAGES-1];

  // R6
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/nmi_acc_guard.sv
module nmi_acc_guard #(
  parameter int ADDR_W   = 8,
  parameter int N_EXEMPT = 6,
  parameter logic [N_EXEMPT*ADDR_W-1:0] EXEMPT_LIST = '0
) (
  input  logic              run,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              err_ev
);
  logic [N_EXEMPT-1:0] hit;

  for (genvar g = 0; g < N_EXEMPT; g++) begin : g_cmp
    assign hit[g] = (acc_addr == EXEMPT_LIST[g*ADDR_W +: ADDR_W]);
  end

  assign err_ev = acc_vld & run & ~(|hit);
endmodule

// File: rtl/nmi_stat_reg.sv
module nmi_stat_reg
  import nmi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t ev,
  input  logic     rd,
  output src_vec_t flags
);
  always_ff @(posedge clk) begin
    if (!rst_n)  flags <= '0;
    else if (rd) flags <= ev;
    else         flags <= flags | ev;
  end

  // R8
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ev == '0) |=> flags == '0);

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit_chk
    // R9
    ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[b] |=> flags[b]);
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[b] && !rd) |=> flags[b]);
  end
endmodule

// File: rtl/nmi_collector.sv
module nmi_collector
  import nmi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int N_EXEMPT    = 6,
  parameter logic [N_EXEMPT*ADDR_W-1:0] EXEMPT_LIST =
    {8'h14, 8'h10, 8'h0C, 8'h08, 8'h04, 8'h00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_run,
  input  logic              host_acc,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              bad_op,
  input  logic              nmi_pin_n,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_q,
  output logic              nmi_req
);
  localparam int PAD_W = STAT_W - N_SRC;

  src_vec_t ev;
  src_vec_t flags;
  logic     err_ev;
  logic     ext_ev;

  nmi_acc_guard #(
    .ADDR_W(ADDR_W), .N_EXEMPT(N_EXEMPT), .EXEMPT_LIST(EXEMPT_LIST)
  ) u_guard (
    .run(eng_run), .acc_vld(host_acc), .acc_addr(host_addr), .err_ev(err_ev)
  );

  nmi_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_n(nmi_pin_n), .fall(ext_ev)
  );

  always_comb begin
    ev          = '0;
    ev[ERR_BIT] = err_ev;
    ev[UND_BIT] = bad_op;
    ev[EXT_BIT] = ext_ev;
  end

  nmi_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd(stat_rd), .flags(flags)
  );

  assign stat_q  = {{PAD_W{1'b0}}, flags};
  assign nmi_req = |flags;

  // R4
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev |-> eng_run);
  // R7
  req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !stat_rd) |=> nmi_req);
endmodule

// File: tb/tb_nmi_collector.sv
module tb_nmi_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_run = 1'b0;
  logic        host_acc = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        bad_op = 1'b0;
  logic        nmi_pin_n = 1'b1;
  logic        stat_rd = 1'b0;
  logic [15:0] stat_q;
  logic        nmi_req;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  nmi_collector dut (
    .clk(clk), .rst_n(rst_n), .eng_run(eng_run), .host_acc(host_acc),
    .host_addr(host_addr), .bad_op(bad_op), .nmi_pin_n(nmi_pin_n),
    .stat_rd(stat_rd), .stat_q(stat_q), .nmi_req(nmi_req)
  );

  // vector: [14] run, [13] acc, [12:5] addr, [4] bad_op, [3] rd, [2:0] flags expected before the edge
  localparam int NV = 30;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0},
    {1'b1,1'b1,8'h20,1'b0,1'b0,3'd0},   // R2
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd4},   // R2 R7
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd4},   // R11
    {1'b0,1'b0,8'h00,1'b0,1'b1,3'd4},   // R8 pre-clear
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0},   // R8
    {1'b1,1'b1,8'h00,1'b0,1'b0,3'd0},   // R3
    {1'b1,1'b1,8'h04,1'b0,1'b0,3'd0},
    {1'b1,1'b1,8'h08,1'b0,1'b0,3'd0},
    {1'b1,1'b1,8'h0C,1'b0,1'b0,3'd0},
    {1'b1,1'b1,8'h10,1'b0,1'b0,3'd0},
    {1'b1,1'b1,8'h14,1'b0,1'b0,3'd0},
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0},   // R3
    {1'b0,1'b1,8'h20,1'b0,1'b0,3'd0},   // R4
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0},   // R4
    {1'b0,1'b0,8'h00,1'b1,1'b0,3'd0},   // R5
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd2},   // R5
    {1'b0,1'b0,8'h00,1'b1,1'b1,3'd2},   // R9
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd2},   // R9
    {1'b1,1'b1,8'h30,1'b0,1'b1,3'd2},   // R9
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd4},
    {1'b0,1'b0,8'h00,1'b1,1'b0,3'd4},
    {1'b0,1'b0,8'h00,1'b0,1'b1,3'd6},   // R8 two flags
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0},
    {1'b0,1'b0,8'h00,1'b0,1'b1,3'd0},   // R8 empty read
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0},
    {1'b1,1'b1,8'h02,1'b0,1'b0,3'd0},   // R3 near miss
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd4},
    {1'b0,1'b0,8'h00,1'b0,1'b1,3'd4},
    {1'b0,1'b0,8'h00,1'b0,1'b0,3'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [2:0] exp);
    chk({req, " stat_q R10"}, stat_q, {13'b0, exp});
    chk({req, " nmi_req R7"}, {15'b0, nmi_req}, {15'b0, |exp});
  endtask

  task automatic idle_inputs();
    eng_run = 1'b0; host_acc = 1'b0; host_addr = '0; bad_op = 1'b0; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_state("R1 reset", 3'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      eng_run   = VEC[i][14];
      host_acc  = VEC[i][13];
      host_addr = VEC[i][12:5];
      bad_op    = VEC[i][4];
      stat_rd   = VEC[i][3];
      #1;
      chk_state($sformatf("R2 R3 R4 R5 R8 R9 R11 vec%0d", i), VEC[i][2:0]);
    end
    @(negedge clk);
    idle_inputs();

    // R6: pin falls before edge k; flag absent after k+1, present after k+2
    nmi_pin_n = 1'b0;
    @(negedge clk); #1; chk_state("R6 edge k", 3'd0);
    @(negedge clk); #1; chk_state("R6 edge k+1", 3'd0);
    @(negedge clk); #1; chk_state("R6 edge k+2", 3'd1);
    repeat (3) @(negedge clk);
    stat_rd = 1'b1; #1; chk_state("R6 R8 read", 3'd1);
    @(negedge clk); stat_rd = 1'b0;
    repeat (4) @(negedge clk);
    #1; chk_state("R6 held low", 3'd0);
    nmi_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    #1; chk_state("R6 rising edge", 3'd0);

    // R1: reset clears recorded flags
    bad_op = 1'b1;
    @(negedge clk); bad_op = 1'b0; #1; chk_state("R5 pre-reset", 3'd2);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1; chk_state("R1 mid reset", 3'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all reqs): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule